// File: doc/BRIEF.md
# Stereo Audio Serial Port

This block moves 16-bit stereo samples between on-chip converters and an external host over a three-wire serial audio link. On the transmit side it takes a left and a right word from a parallel bus, once per frame, and shifts them out on a serial data line. On the receive side it collects a left and a right word from a serial data line and presents them together on a parallel bus with a one-cycle strobe.

Three framings are supported: I2S, left-justified and right-justified. The frame clock marks the channel, and the framing sets where each 16-bit word sits inside its half-frame. The block can drive the bit clock and the frame clock itself. In that case it derives them from the master clock, which runs at 256 times the sample rate, or at 512 times with the divide-by-two enabled. Otherwise it follows clocks supplied from outside. The bit clock runs at 64 or 32 times the sample rate. Each bidirectional clock pad is exposed as an input, an output and an output enable.

Top module: `audio_serial_port`

## Requirements
- R1: While reset is held, bclk_o, sdo, rx_valid and tx_take are 0, and lrck_o sits at the left-channel level.
- R2: In master mode, the bit clock period in master-clock cycles is 4 (64fs) or 8 (32fs), and doubles when cfg_mclk_div2 is 1. lrck_o changes every 32 (64fs) or 16 (32fs) bit clocks, so one frame always lasts 256 master-clock cycles before the divider.
- R3: In master mode, lrck_o changes only on a bit-clock falling edge. It is low for the left channel when cfg_fmt=0 (I2S) and high for the left channel for every other format code.
- R4: With cfg_fmt=0 (I2S), each word's MSB occupies the bit slot that starts one bit clock after the frame-clock edge. The remaining bits follow MSB first.
- R5: With cfg_fmt=1 (left-justified; code 3 acts the same), the MSB occupies the bit slot that starts at the frame-clock edge.
- R6: With cfg_fmt=2 (right-justified), the LSB occupies the last bit slot of each half-frame.
- R7: sdo changes only after a bit-clock falling edge, and is 0 in every bit slot not carrying sample data.
- R8: sdi is sampled on bit-clock rising edges using the same slot mapping. Once per frame, after the right word completes, rx_valid pulses for one cycle with the left and right words on rx_left and rx_right.
- R9: With cfg_master=0, bclk_oe and lrck_oe are 0 and the block follows bclk_i and lrck_i (three master-clock cycles of synchronizer latency).
- R10: In slave mode, a frame with either half-frame length other than the selected ratio produces no rx_valid. Correct frames resume delivery.
- R11: tx_take pulses for one cycle at the start of each left half-frame. tx_left and tx_right are captured in that cycle and are sent in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| cfg_master | input | 1 | 1: drive bit and frame clocks; 0: follow external clocks |
| cfg_fmt | input | 2 | 0 I2S, 1 left-justified, 2 right-justified, 3 left-justified |
| cfg_bclk64 | input | 1 | 1: 64fs bit clock; 0: 32fs |
| cfg_mclk_div2 | input | 1 | 1: master clock is 512fs, halved internally |
| bclk_i | input | 1 | External bit clock (slave) |
| bclk_o | output | 1 | Generated bit clock (master) |
| bclk_oe | output | 1 | Bit clock pad output enable |
| lrck_i | input | 1 | External frame clock (slave) |
| lrck_o | output | 1 | Generated frame clock (master) |
| lrck_oe | output | 1 | Frame clock pad output enable |
| sdi | input | 1 | Serial playback data in |
| sdo | output | 1 | Serial record data out |
| tx_left | input | 16 | Left word to send |
| tx_right | input | 16 | Right word to send |
| tx_take | output | 1 | Words captured this cycle |
| rx_left | output | 16 | Received left word |
| rx_right | output | 16 | Received right word |
| rx_valid | output | 1 | Received pair valid, one cycle |

## Verification
A wrong slot counter or a wrong channel flag shows up at the ports within one half-frame. The next word decoded from sdo comes out shifted, swapped between channels, or with ones in slots that should be zero. A bad frame-length or lock flag shows up a frame later, when rx_valid is missing or occurs with stale words. A wrong clock divider shows up as a wrong bit-clock or frame-clock period within the first frame after reset. Each case is compared against a framing model, under random words and under directed words: MSB only, LSB only, all ones and all zeros.

// File: rtl/audio_serial_port.sv
module audio_serial_port #(
  parameter int SW = 16,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_master,
  input  logic [1:0]    cfg_fmt,
  input  logic          cfg_bclk64,
  input  logic          cfg_mclk_div2,
  input  logic          bclk_i,
  output logic          bclk_o,
  output logic          bclk_oe,
  input  logic          lrck_i,
  output logic          lrck_o,
  output logic          lrck_oe,
  input  logic          sdi,
  output logic          sdo,
  input  logic [SW-1:0] tx_left,
  input  logic [SW-1:0] tx_right,
  output logic          tx_take,
  output logic [SW-1:0] rx_left,
  output logic [SW-1:0] rx_right,
  output logic          rx_valid
);
  localparam int IW = $clog2(SW);
  localparam logic [CW-1:0] SMAX = '1;
  localparam logic [CW-1:0] WLAST = CW'(SW - 1);

  function automatic logic in_data(input logic [CW-1:0] s, input logic r, input logic [CW-1:0] last);
    return r ? (s >= last - WLAST && s <= last) : (s <= WLAST);
  endfunction

  function automatic logic [IW-1:0] bit_idx(input logic [CW-1:0] s, input logic r, input logic [CW-1:0] last);
    logic [CW-1:0] t;
    t = r ? last - s : WLAST - s;
    return t[IW-1:0];
  endfunction

  wire i2s = (cfg_fmt == 2'd0);
  wire rj  = (cfg_fmt == 2'd2);
  wire [CW-1:0] hlast = cfg_bclk64 ? CW'(31) : CW'(15);
  wire [2:0]    mlim  = cfg_bclk64 ? 3'd3 : 3'd7;

  // master clock generation
  logic men, bclk_m, mhalf, mrise_d, mfall_d;
  logic [2:0] mcnt;
  logic [CW-1:0] mbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      men <= 1'b0; mcnt <= '0; bclk_m <= 1'b0; mbit <= '0; mhalf <= 1'b0;
      mrise_d <= 1'b0; mfall_d <= 1'b0;
    end else begin
      men <= cfg_mclk_div2 ? ~men : 1'b1;
      mrise_d <= 1'b0;
      mfall_d <= 1'b0;
      if (cfg_master && men) begin
        if (mcnt == mlim) begin
          mcnt <= '0;
          bclk_m <= 1'b0;
          mfall_d <= 1'b1;
          if (mbit == hlast) begin
            mbit <= '0;
            mhalf <= ~mhalf;
          end else begin
            mbit <= mbit + 1'b1;
          end
        end else begin
          mcnt <= mcnt + 1'b1;
          if (mcnt == (mlim >> 1)) begin
            bclk_m <= 1'b1;
            mrise_d <= 1'b1;
          end
        end
      end
    end
  end

  assign bclk_o  = bclk_m;
  assign lrck_o  = i2s ? mhalf : ~mhalf;
  assign bclk_oe = cfg_master;
  assign lrck_oe = cfg_master;

  // slave synchronizers
  logic [2:0] bsy;
  logic [1:0] lsy, dsy;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsy <= '0; lsy <= '0; dsy <= '0;
    end else begin
      bsy <= {bsy[1:0], bclk_i};
      lsy <= {lsy[0], lrck_i};
      dsy <= {dsy[0], sdi};
    end
  end

  wire ev_rise = cfg_master ? mrise_d : (bsy[1] & ~bsy[2]);
  wire ev_fall = cfg_master ? mfall_d : (~bsy[1] & bsy[2]);
  wire lr      = cfg_master ? lrck_o : lsy[1];
  wire din     = cfg_master ? sdi : dsy[1];

  // slot engine
  logic fp1, fp2, chl, locked, ok_l;
  logic [CW-1:0] slot;
  logic [SW-1:0] shl, shr, rxl, rxr;

  wire bnd   = i2s ? (fp1 != fp2) : (lr != fp1);
  wire nleft = i2s ? ~fp1 : lr;
  wire [CW-1:0] nslot = bnd ? '0 : ((slot == SMAX) ? SMAX : slot + 1'b1);
  wire nchl  = bnd ? nleft : chl;
  wire load  = bnd && nleft;
  wire full_half = locked && (slot == hlast);
  wire [SW-1:0] word = nchl ? (load ? tx_left : shl) : shr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp1 <= 1'b0; fp2 <= 1'b0; chl <= 1'b0; locked <= 1'b0; ok_l <= 1'b0;
      slot <= '0; shl <= '0; shr <= '0; rxl <= '0; rxr <= '0;
      rx_left <= '0; rx_right <= '0; rx_valid <= 1'b0; tx_take <= 1'b0; sdo <= 1'b0;
    end else begin
      tx_take <= 1'b0;
      rx_valid <= 1'b0;
      if (ev_fall) begin
        fp1 <= lr;
        fp2 <= fp1;
        slot <= nslot;
        chl <= nchl;
        locked <= locked | bnd;
        sdo <= (locked | bnd) && in_data(nslot, rj, hlast) ? word[bit_idx(nslot, rj, hlast)] : 1'b0;
        if (load) begin
          shl <= tx_left;
          shr <= tx_right;
          tx_take <= 1'b1;
        end
        if (bnd) begin
          if (nleft) begin
            if (ok_l && full_half && !chl) begin
              rx_valid <= 1'b1;
              rx_left <= rxl;
              rx_right <= rxr;
            end
          end else begin
            ok_l <= full_half && chl;
          end
        end
      end
      if (ev_rise && locked && in_data(slot, rj, hlast)) begin
        if (chl) rxl[bit_idx(slot, rj, hlast)] <= din;
        else     rxr[bit_idx(slot, rj, hlast)] <= din;
      end
    end
  end

  a_r3_lrck_on_bclk_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && lrck_o != $past(lrck_o)) |-> $fell(bclk_o));
  a_r7_sdo_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && sdo != $past(sdo)) |-> !bclk_o);
  a_r7_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !sdo);
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r11_take_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> !tx_take);
endmodule

// File: tb/tb_audio_serial_port.sv
`timescale 1ns/1ps
module tb_audio_serial_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_master = 1'b1, cfg_bclk64 = 1'b1, cfg_mclk_div2 = 1'b0;
  logic [1:0] cfg_fmt = 2'd0;
  logic tb_bclk = 1'b0, tb_lrck = 1'b0, sdi = 1'b0;
  logic [15:0] txl = '0, txr = '0;
  logic bclk_o, bclk_oe, lrck_o, lrck_oe, sdo, tx_take, rx_valid;
  logic [15:0] rx_left, rx_right;

  audio_serial_port dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_fmt(cfg_fmt),
    .cfg_bclk64(cfg_bclk64), .cfg_mclk_div2(cfg_mclk_div2),
    .bclk_i(tb_bclk), .bclk_o(bclk_o), .bclk_oe(bclk_oe),
    .lrck_i(tb_lrck), .lrck_o(lrck_o), .lrck_oe(lrck_oe),
    .sdi(sdi), .sdo(sdo), .tx_left(txl), .tx_right(txr), .tx_take(tx_take),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid));

  always #2 clk = ~clk;

  wire bclk_w = cfg_master ? bclk_o : tb_bclk;
  wire lrck_w = cfg_master ? lrck_o : tb_lrck;

  int n_chk = 0, n_bad = 0, cyc = 0, H = 32;
  bit finished = 0;
  logic [15:0] sdl, sdr, dl, dr, dec_l, dec_r, rxl_o, rxr_o;
  int dec_cnt, zero_err, vcnt, tcnt, lastb, bper, lastl, lper, eslot;
  logic eprev, eprev2, eleft, elock;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit bdata(input int s);
    return (cfg_fmt == 2'd2) ? (s >= H - 16 && s < H) : (s < 16);
  endfunction
  function automatic int bidx(input int s);
    return (cfg_fmt == 2'd2) ? H - 1 - s : 15 - s;
  endfunction

  always @(posedge clk) cyc++;

  // framing model: slot tracker updated on bit-clock falls
  always @(negedge bclk_w) begin
    logic lr, bnd, nl;
    #1;
    lr = lrck_w;
    bnd = (cfg_fmt == 2'd0) ? (eprev != eprev2) : (lr != eprev);
    nl  = (cfg_fmt == 2'd0) ? !eprev : lr;
    if (bnd) begin
      if (nl && elock) begin dec_l = dl; dec_r = dr; dec_cnt++; end
      eslot = 0; eleft = nl; elock = 1'b1;
    end else begin
      eslot++;
    end
    eprev2 = eprev; eprev = lr;
    if (elock && bdata(eslot)) sdi = eleft ? sdl[bidx(eslot)] : sdr[bidx(eslot)];
    else sdi = 1'b0;
  end

  always @(posedge bclk_w) begin
    #1;
    bper = cyc - lastb; lastb = cyc;
    if (elock) begin
      if (bdata(eslot)) begin
        if (eleft) dl[bidx(eslot)] = sdo; else dr[bidx(eslot)] = sdo;
      end else if (sdo) zero_err++;
    end
  end

  always @(lrck_w) begin lper = cyc - lastl; lastl = cyc; end

  always @(negedge clk) begin
    if (rx_valid) begin vcnt++; rxl_o = rx_left; rxr_o = rx_right; end
    if (tx_take) tcnt++;
  end

  task automatic setup(input bit m, input logic [1:0] f, input bit r64, input bit d2);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_master = m; cfg_fmt = f; cfg_bclk64 = r64; cfg_mclk_div2 = d2;
    tb_bclk = 1'b0; tb_lrck = 1'b0;
    H = r64 ? 32 : 16;
    repeat (4) @(negedge clk);
    eprev = 1'b0; eprev2 = 1'b0; eslot = 0; eleft = 1'b0; elock = 1'b0;
    dec_cnt = 0; zero_err = 0; vcnt = 0; tcnt = 0;
    chk(bclk_o == 1'b0 && sdo == 1'b0 && rx_valid == 1'b0 && tx_take == 1'b0, "R1 idle outputs",
        {bclk_o, sdo, rx_valid, tx_take}, 0);
    chk(lrck_o == (f != 2'd0), "R1 R3 lrck left level", lrck_o, (f != 2'd0));
    rst_n = 1'b1;
  endtask

  task automatic data_checks();
    string req;
    req = (cfg_fmt == 2'd0) ? "R4" : (cfg_fmt == 2'd2) ? "R6" : "R5";
    chk(dec_cnt >= 2, {req, " frames seen"}, dec_cnt, 2);
    chk(dec_l == txl, {req, " left word on sdo"}, dec_l, txl);
    chk(dec_r == txr, {req, " right word on sdo"}, dec_r, txr);
    chk(zero_err == 0, "R7 unused slots zero", zero_err, 0);
    chk(vcnt >= 2, "R8 rx_valid count", vcnt, 2);
    chk(rxl_o == sdl, "R8 rx_left", rxl_o, sdl);
    chk(rxr_o == sdr, "R8 rx_right", rxr_o, sdr);
  endtask

  task automatic master_case(input int k, input logic [1:0] f, input bit r64, input bit d2);
    int fr, p;
    setup(1'b1, f, r64, d2);
    fr = d2 ? 512 : 256;
    p = (r64 ? 4 : 8) * (d2 ? 2 : 1);
    sdl = 16'($urandom); sdr = 16'($urandom);
    txl = 16'($urandom); txr = 16'($urandom);
    repeat (3 * fr) @(negedge clk);
    if (k == 0) begin txl = 16'h8000; txr = 16'h0001; end
    else if (k == 1) begin txl = 16'hFFFF; txr = 16'h0000; sdl = 16'h0001; sdr = 16'h8000; end
    else begin txl = 16'($urandom); txr = 16'($urandom); end
    repeat (4 * fr) @(negedge clk);
    chk(bper == p, "R2 bit clock period", bper, p);
    chk(lper == H * p, "R2 frame clock half period", lper, H * p);
    chk(tcnt >= 5, "R11 tx_take per frame", tcnt, 5);
    chk(bclk_oe && lrck_oe, "R9 master drives clocks", {bclk_oe, lrck_oe}, 3);
    data_checks();
  endtask

  task automatic slave_frames(input int n, input int hl);
    logic left;
    left = (cfg_fmt != 2'd0);
    for (int fr = 0; fr < n; fr++)
      for (int h = 0; h < 2; h++)
        for (int b = 0; b < hl; b++) begin
          @(negedge clk);
          tb_bclk = 1'b0;
          if (b == 0) tb_lrck = (h == 0) ? left : !left;
          repeat (5) @(negedge clk);
          tb_bclk = 1'b1;
          repeat (6) @(negedge clk);
        end
  endtask

  task automatic slave_case(input logic [1:0] f, input bit r64);
    setup(1'b0, f, r64, 1'b0);
    sdl = 16'($urandom); sdr = 16'($urandom);
    txl = 16'($urandom); txr = 16'($urandom);
    slave_frames(6, H);
    chk(!bclk_oe && !lrck_oe, "R9 slave releases clocks", {bclk_oe, lrck_oe}, 0);
    data_checks();
    slave_frames(1, H - 2);
    vcnt = 0;
    slave_frames(3, H - 2);
    chk(vcnt == 0, "R10 short frames dropped", vcnt, 0);
    sdl = 16'($urandom); sdr = 16'($urandom);
    slave_frames(5, H);
    chk(vcnt >= 2, "R10 delivery resumes", vcnt, 2);
    chk(rxl_o == sdl && rxr_o == sdr, "R10 R9 words after resume", rxl_o, sdl);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    int k;
    void'($urandom(32'd4242));
    k = 0;
    for (int f = 0; f < 3; f++)
      for (int r = 0; r < 2; r++)
        for (int d = 0; d < 2; d++) begin
          master_case(k, 2'(f), r[0], d[0]);
          k++;
        end
    master_case(2, 2'd3, 1'b1, 1'b0);
    for (int f = 0; f < 3; f++)
      for (int r = 0; r < 2; r++)
        slave_case(2'(f), r[0]);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule